// File: doc/BRIEF.md
# Logic Self-Test Engine with Phased Control Points

This block runs a complete logic self-test of a full-scan circuit without an external tester. A pseudo-random generator built from a linear feedback shift register fills several scan chains at once. The engine then pulses one capture cycle into the circuit under test. The bits that come out of the chains during the following load are folded into a multiple-input signature register. After a programmed number of patterns, a last unload pass drains the final capture. The engine then raises done and holds the signature for comparison against a known-good value.

Some faults are hard to reach with random stimulus. To help with them, the pattern counter is split into phases. A phase decoder enables a different group of AND-type control points in each phase, and each enabled point forces its circuit node low. The chains hold unknown contents before the first load, so the signature register ignores the first unload pass. This keeps uninitialized values out of the signature.

Top module: `lbist_engine`

## Requirements
- R1: While reset is asserted and after it is released with no start, scan_en_o, tp_en_o and done_o are low and signature_o is zero.
- R2: A start pulse accepted at a clock edge begins a session in the next cycle. Each of the N programmed patterns takes CHAIN_LEN cycles with scan_en_o high followed by one capture cycle with scan_en_o low. After the last capture, an unload pass of CHAIN_LEN cycles with scan_en_o high follows. done_o rises N*(CHAIN_LEN+1)+CHAIN_LEN cycles after the first session cycle.
- R3: The generator is 16 bits wide and is reloaded to seed 16'hACE1 on each accepted start. On every cycle with scan_en_o high it shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. In other cycles it holds. Chain c receives generator bit 15-c on scan_in_o[c].
- R4: The signature register is cleared to zero on each accepted start. On a compacting cycle it shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10, and then XORs scan_out_i into its low bits (chain c into bit c). It holds in all other cycles.
- R5: The phase of pattern p is (p / 2) mod 4. During the shift and capture cycles of pattern p, tp_en_o bits [2*phase+1 : 2*phase] are high and all other bits are low. tp_en_o is all zero when idle, during the unload pass and when done.
- R6: Control points are AND-type: tp_nodes_o equals tp_nodes_i AND NOT tp_en_o, in every cycle.
- R7: Once done_o is high, it stays high and signature_o is unchanged until the next start. A start accepted while done is high begins a new session, and done_o falls in the first session cycle.
- R8: A start pulse received while a session is running has no effect on the sequence, the stimulus or the signature.
- R9: A programmed count of zero finishes at once. done_o is high in the cycle after the start, with a signature of zero and no scan cycles.
- R10: No signature update happens during the first shift pass of a session. The signature therefore does not depend on the chain contents present before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start request |
| pat_count_i | input | PAT_CNT_W | Number of patterns, sampled on start |
| scan_en_o | output | 1 | Scan enable to the circuit under test (high = shift) |
| scan_in_o | output | NUM_CHAINS | Serial data into each scan chain |
| scan_out_i | input | NUM_CHAINS | Serial data out of each scan chain |
| tp_en_o | output | NUM_PHASES*TP_PER_PHASE | Control-point enables, one per point |
| tp_nodes_i | input | NUM_PHASES*TP_PER_PHASE | Functional values at the control-point nodes |
| tp_nodes_o | output | NUM_PHASES*TP_PER_PHASE | Node values after AND-type forcing |
| signature_o | output | MISR_W | Test signature |
| done_o | output | 1 | Session complete, signature valid |

## Verification
The bench goes after the first unload pass. It preloads the chains with two different garbage patterns and requires identical signatures; a design that compacted the first pass would give two signatures. It follows the phase decoder through a nine-pattern run so that the phase wraps back to zero. A decoder that did not wrap, or that left points enabled into the unload pass, would corrupt tp_en_o and the forced nodes. It also covers a single-pattern run, a zero count, a start pulse in the middle of a session, and a restart from the done state. A design that miscounted the capture boundary, restarted on a busy start, or failed to reseed the generator or clear the signature would show a wrong scan_en_o cycle, wrong scan_in_o bits or a wrong final signature.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_DONE
  } lbist_state_e;
endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int unsigned      WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
  parameter logic [WIDTH-1:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] lfsr_q;
  logic             fb;

  assign fb = ^(lfsr_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (load_i) lfsr_q <= SEED;
    else if (adv_i)  lfsr_q <= {lfsr_q[WIDTH-2:0], fb};
  end

  assign state_o = lfsr_q;

  p_lfsr_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  p_lfsr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(lfsr_q));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int unsigned      WIDTH = 16,
  parameter int unsigned      IN_W  = 4,
  parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [WIDTH-1:0] sig_o
);
  logic [WIDTH-1:0] misr_q;
  logic             fb;

  assign fb = ^(misr_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     misr_q <= '0;
    else if (clr_i)  misr_q <= '0;
    else if (en_i)   misr_q <= {misr_q[WIDTH-2:0], fb} ^ WIDTH'(data_i);
  end

  assign sig_o = misr_q;

  p_misr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (misr_q == '0));
  p_misr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(misr_q));
endmodule

// File: rtl/lbist_phase_dec.sv
module lbist_phase_dec #(
  parameter int unsigned PAT_CNT_W      = 8,
  parameter int unsigned NUM_PHASES     = 4,
  parameter int unsigned PHASE_LEN_LOG2 = 1,
  parameter int unsigned TP_PER_PHASE   = 2,
  localparam int unsigned NUM_TP        = NUM_PHASES * TP_PER_PHASE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAT_CNT_W-1:0] pat_idx_i,
  input  logic                 active_i,
  output logic [NUM_TP-1:0]    tp_en_o
);
  logic [PAT_CNT_W-1:0]  phase;
  logic [NUM_PHASES-1:0] phase_sel;

  assign phase = (pat_idx_i >> PHASE_LEN_LOG2) % PAT_CNT_W'(NUM_PHASES);

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    assign phase_sel[p] = active_i && (phase == PAT_CNT_W'(p));
    assign tp_en_o[p*TP_PER_PHASE +: TP_PER_PHASE] = {TP_PER_PHASE{phase_sel[p]}};
  end

  p_tp_onegroup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tp_en_o) == (active_i ? TP_PER_PHASE : 0));
  p_tp_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (tp_en_o == '0));
  p_phase_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_sel));
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 8,
  parameter int unsigned PAT_CNT_W = 8,
  localparam int unsigned BIT_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [PAT_CNT_W-1:0] pat_count_i,
  output logic                 scan_en_o,
  output logic                 lfsr_adv_o,
  output logic                 seed_load_o,
  output logic                 misr_en_o,
  output logic                 misr_clr_o,
  output logic [PAT_CNT_W-1:0] pat_idx_o,
  output logic                 pat_active_o,
  output logic                 done_o
);
  lbist_state_e         state_q, state_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [PAT_CNT_W-1:0] pat_q, pat_d;
  logic [PAT_CNT_W-1:0] num_q, num_d;
  logic                 accept;
  logic                 last_bit;
  logic                 last_pat;

  assign accept   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign last_bit = (bit_q == BIT_W'(CHAIN_LEN - 1));
  assign last_pat = ((pat_q + PAT_CNT_W'(1)) == num_q);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    pat_d   = pat_q;
    num_d   = num_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          num_d   = pat_count_i;
          pat_d   = '0;
          bit_d   = '0;
          state_d = (pat_count_i == '0) ? ST_DONE : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (last_bit) begin
          bit_d   = '0;
          state_d = ST_CAPTURE;
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end
      ST_CAPTURE: begin
        pat_d   = pat_q + PAT_CNT_W'(1);
        state_d = last_pat ? ST_UNLOAD : ST_SHIFT;
      end
      ST_UNLOAD: begin
        if (last_bit) begin
          bit_d   = '0;
          state_d = ST_DONE;
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      pat_q   <= '0;
      num_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      pat_q   <= pat_d;
      num_q   <= num_d;
    end
  end

  assign scan_en_o    = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
  assign lfsr_adv_o   = scan_en_o;
  assign seed_load_o  = accept;
  assign misr_clr_o   = accept;
  // first shift pass unloads uninitialized chains: keep it out of the signature
  assign misr_en_o    = ((state_q == ST_SHIFT) && (pat_q != '0)) || (state_q == ST_UNLOAD);
  assign pat_idx_o    = pat_q;
  assign pat_active_o = (state_q == ST_SHIFT) || (state_q == ST_CAPTURE);
  assign done_o       = (state_q == ST_DONE);

  p_capture_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPTURE) |=> (state_q == ST_SHIFT || state_q == ST_UNLOAD));
  p_shift_to_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && last_bit) |=> (state_q == ST_CAPTURE));
  p_busy_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && scan_en_o) |=> $stable(num_q));
  p_first_pass_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && pat_q == '0) |-> !misr_en_o);
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int unsigned NUM_CHAINS     = 4,
  parameter int unsigned CHAIN_LEN      = 8,
  parameter int unsigned LFSR_W         = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int unsigned MISR_W         = 16,
  parameter logic [MISR_W-1:0] MISR_TAPS = 16'hB400,
  parameter int unsigned PAT_CNT_W      = 8,
  parameter int unsigned NUM_PHASES     = 4,
  parameter int unsigned PHASE_LEN_LOG2 = 1,
  parameter int unsigned TP_PER_PHASE   = 2,
  localparam int unsigned NUM_TP        = NUM_PHASES * TP_PER_PHASE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PAT_CNT_W-1:0]  pat_count_i,
  output logic                  scan_en_o,
  output logic [NUM_CHAINS-1:0] scan_in_o,
  input  logic [NUM_CHAINS-1:0] scan_out_i,
  output logic [NUM_TP-1:0]     tp_en_o,
  input  logic [NUM_TP-1:0]     tp_nodes_i,
  output logic [NUM_TP-1:0]     tp_nodes_o,
  output logic [MISR_W-1:0]     signature_o,
  output logic                  done_o
);
  logic                 lfsr_adv, seed_load, misr_en, misr_clr, pat_active;
  logic [PAT_CNT_W-1:0] pat_idx;
  logic [LFSR_W-1:0]    lfsr_state;

  lbist_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .PAT_CNT_W (PAT_CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .pat_count_i  (pat_count_i),
    .scan_en_o    (scan_en_o),
    .lfsr_adv_o   (lfsr_adv),
    .seed_load_o  (seed_load),
    .misr_en_o    (misr_en),
    .misr_clr_o   (misr_clr),
    .pat_idx_o    (pat_idx),
    .pat_active_o (pat_active),
    .done_o       (done_o)
  );

  lbist_lfsr #(
    .WIDTH (LFSR_W),
    .TAPS  (LFSR_TAPS),
    .SEED  (LFSR_SEED)
  ) u_prpg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load),
    .adv_i   (lfsr_adv),
    .state_o (lfsr_state)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    assign scan_in_o[c] = lfsr_state[LFSR_W-1-c];
  end

  lbist_misr #(
    .WIDTH (MISR_W),
    .IN_W  (NUM_CHAINS),
    .TAPS  (MISR_TAPS)
  ) u_misr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (misr_clr),
    .en_i   (misr_en),
    .data_i (scan_out_i),
    .sig_o  (signature_o)
  );

  lbist_phase_dec #(
    .PAT_CNT_W      (PAT_CNT_W),
    .NUM_PHASES     (NUM_PHASES),
    .PHASE_LEN_LOG2 (PHASE_LEN_LOG2),
    .TP_PER_PHASE   (TP_PER_PHASE)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pat_idx_i (pat_idx),
    .active_i  (pat_active),
    .tp_en_o   (tp_en_o)
  );

  for (genvar k = 0; k < NUM_TP; k++) begin : g_tp
    assign tp_nodes_o[k] = tp_nodes_i[k] & ~tp_en_o[k];
  end

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(signature_o)));
  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scan_en_o && tp_en_o == '0));
endmodule

// File: tb/tb_lbist_engine.sv
module tb_lbist_engine;
  localparam int NC = 4;
  localparam int CL = 8;
  localparam int NTP = 8;
  localparam logic [15:0] SEED = 16'hACE1;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             start_i;
  logic [7:0]       pat_count_i;
  logic             scan_en_o;
  logic [NC-1:0]    scan_in_o;
  logic [NC-1:0]    scan_out_i;
  logic [NTP-1:0]   tp_en_o;
  logic [NTP-1:0]   tp_nodes_i;
  logic [NTP-1:0]   tp_nodes_o;
  logic [15:0]      signature_o;
  logic             done_o;

  int vectors = 0;
  int fails   = 0;

  always #10 clk_i = ~clk_i;

  lbist_engine dut (
    .clk_i, .rst_ni, .start_i, .pat_count_i, .scan_en_o, .scan_in_o,
    .scan_out_i, .tp_en_o, .tp_nodes_i, .tp_nodes_o, .signature_o, .done_o
  );

  // circuit under test: NC chains of CL flops
  logic [CL-1:0] ch [NC];
  logic          preload_req = 1'b0;
  logic [CL-1:0] preload_val = '0;

  for (genvar c = 0; c < NC; c++) begin : g_out
    assign scan_out_i[c] = ch[c][CL-1];
  end

  always @(posedge clk_i) begin
    if (preload_req) begin
      for (int c = 0; c < NC; c++) ch[c] <= preload_val ^ CL'(c * 37);
    end else if (scan_en_o) begin
      for (int c = 0; c < NC; c++) ch[c] <= {ch[c][CL-2:0], scan_in_o[c]};
    end else if (rst_ni) begin
      for (int c = 0; c < NC; c++)
        ch[c] <= {ch[c][CL-2:0], ch[c][CL-1]} ^ ch[(c+1)%NC] ^ CL'(tp_nodes_o[2*c +: 2]);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step16(input logic [15:0] s, input logic [15:0] d);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb} ^ d;
  endfunction

  task automatic run_session(input int n, input logic [CL-1:0] garbage, input bit poke,
                             output logic [15:0] sig);
    logic [15:0]    lf;
    logic [15:0]    ms;
    logic [NC-1:0]  exp_in;
    logic [NTP-1:0] exp_tp;
    int             total;
    bit             shifting;
    @(negedge clk_i);
    preload_val = garbage;
    preload_req = 1'b1;
    @(negedge clk_i);
    preload_req = 1'b0;
    tp_nodes_i  = '1;
    pat_count_i = 8'(n);
    start_i     = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lf = SEED;
    ms = '0;
    total = (n == 0) ? 0 : n * (CL + 1) + CL;
    for (int t = 0; t < total; t++) begin
      int p = t / (CL + 1);
      int r = t % (CL + 1);
      shifting = (p >= n) || (r < CL);
      exp_tp = '0;
      if (p < n) exp_tp = NTP'(2'b11) << (2 * ((p / 2) % 4));
      for (int c = 0; c < NC; c++) exp_in[c] = lf[15-c];
      chk(scan_en_o == shifting, "R2 scan_en sequence", 64'(scan_en_o), 64'(shifting));
      if (shifting) chk(scan_in_o == exp_in, "R3 stimulus bits", 64'(scan_in_o), 64'(exp_in));
      chk(tp_en_o == exp_tp, "R5 phase test points", 64'(tp_en_o), 64'(exp_tp));
      chk(tp_nodes_o == (tp_nodes_i & ~exp_tp), "R6 AND forcing", 64'(tp_nodes_o),
          64'(tp_nodes_i & ~exp_tp));
      chk(done_o == 1'b0, "R2 done low while running", 64'(done_o), 64'd0);
      if (shifting) begin
        if (t >= CL) ms = step16(ms, 16'(scan_out_i));
        lf = step16(lf, 16'd0);
      end
      start_i = (poke && t == 3);  // R8: pulse while busy
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R2 done at end", 64'(done_o), 64'd1);
    chk(signature_o == ms, "R4 signature", 64'(signature_o), 64'(ms));
    chk(scan_en_o == 1'b0 && tp_en_o == '0, "R5 quiet when done",
        64'({scan_en_o, tp_en_o}), 64'd0);
    sig = signature_o;
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; start_i = 1'b0; pat_count_i = '0; tp_nodes_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !scan_en_o && tp_en_o == '0 && signature_o == '0, "R1 in reset",
        64'({done_o, scan_en_o, tp_en_o, signature_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !scan_en_o && tp_en_o == '0 && signature_o == '0, "R1 after release",
        64'({done_o, scan_en_o, tp_en_o, signature_o}), 64'd0);
  endtask

  task automatic test_idle_gating();
    tp_nodes_i = 8'hA5;
    @(negedge clk_i);
    chk(tp_nodes_o == 8'hA5, "R6 idle passthrough", 64'(tp_nodes_o), 64'hA5);
    tp_nodes_i = 8'h5A;
    @(negedge clk_i);
    chk(tp_nodes_o == 8'h5A, "R6 idle passthrough", 64'(tp_nodes_o), 64'h5A);
  endtask

  task automatic test_hold(input logic [15:0] sig);
    repeat (5) begin
      @(negedge clk_i);
      chk(done_o == 1'b1, "R7 done held", 64'(done_o), 64'd1);
      chk(signature_o == sig, "R7 signature held", 64'(signature_o), 64'(sig));
    end
  endtask

  task automatic test_x_block();
    logic [15:0] sa, sb;
    run_session(6, 8'h3C, 1'b0, sa);
    test_hold(sa);
    // restart straight from done, different chain garbage, busy start pulse (R8)
    run_session(6, 8'hC3, 1'b1, sb);
    chk(sa == sb, "R10 garbage independent", 64'(sb), 64'(sa));
  endtask

  task automatic test_wrap();
    logic [15:0] s;
    run_session(9, 8'h96, 1'b0, s);
    chk(s != 16'd0, "R4 nonzero signature", 64'(s), 64'd1);
  endtask

  task automatic test_single();
    logic [15:0] s;
    run_session(1, 8'hFF, 1'b0, s);
  endtask

  task automatic test_zero();
    logic [15:0] s;
    run_session(0, 8'h00, 1'b0, s);
    chk(s == 16'd0, "R9 zero count signature", 64'(s), 64'd0);
    @(negedge clk_i);
    chk(done_o && !scan_en_o, "R9 zero count done", 64'({done_o, scan_en_o}), 64'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_idle_gating();
    test_x_block();
    test_wrap();
    test_single();
    test_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule